// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a slower word-wide memory bus. Fetch addresses arrive already translated to physical form. Each address is split into three fields: a line offset, a directory index and a tag. The index selects one directory entry, which holds a tag and a valid flag. When the entry is valid and its tag matches, the addressed 32-bit word is returned in the same cycle. No memory traffic takes place.

On a miss the fetch is stalled and the whole line is read from memory, one 32-bit word per request/acknowledge beat, starting at word 0. The requested word goes to the processor in the cycle its beat completes. Every word is written into the data array. The tag is stored and the valid flag is set only after the last beat. Any other fetch made while a refill is running waits until the refill is done. The cache is read-only and has no write path.

The capacity is a parameter (512 B, 4 KB, 8 KB, 16 KB or 32 KB). The 32 KB build uses 32-byte lines, and every other build uses 16-byte lines. With the default 8 KB build there are 512 lines: the index is address bits [12:4] and the tag is bits [31:13]. Each directory entry is therefore 19 tag bits plus a valid bit.

Top module: `fetch_line_cache`

## Requirements
- R1: A fetch whose line is valid with a matching tag asserts fetch_ack in the same cycle as fetch_req, returns the word, and starts no memory read.
- R2: Direct mapping (default build): the index is fetch_addr[12:4] and the tag is fetch_addr[31:13]. A fill for one tag replaces any other tag held at the same index, so the displaced address misses when it is fetched again.
- R3: Reset clears every valid flag. After reset mem_req and fetch_ack are low, and the first fetch to any line misses.
- R4: A miss reads the full line as 4 word reads, at addresses line base + 0, 4, 8 and 12 in that order. Each address is word aligned and stays stable while mem_req is high and mem_ack is low. A beat completes on a cycle with mem_req and mem_ack both high.
- R5: The missed word is forwarded during the refill. fetch_ack is asserted in the cycle its beat is acknowledged, and fetch_rdata equals mem_rdata. This includes the case where it is the last word (offset 12), so forwarding and line completion fall in the same cycle.
- R6: While a refill runs, no other fetch is acknowledged. A fetch made during the refill is served only after the refill finishes.
- R7: The line is marked valid only after its last word is written. After that, every word of the line hits.
- R8: On a hit, the word is chosen by fetch_addr[3:2], and the returned data equals the memory contents at that word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; invalidates all lines |
| fetch_req | input | 1 | Fetch request, held until fetch_ack |
| fetch_addr | input | 32 | Physical fetch address, held with fetch_req |
| fetch_ack | output | 1 | Fetch completes this cycle |
| fetch_rdata | output | 32 | Instruction word, valid with fetch_ack |
| mem_req | output | 1 | Memory word read request, high during refill |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_ack | input | 1 | Memory beat acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
Two events can land on the same clock edge: forwarding the missed word and completing the line fill. They coincide when the missed word is the line's last word. The bench provokes this with directed fetches to offset 12 under random memory acknowledge delays. It then judges the same edge from both sides: the forwarded data must match memory, and the very next fetch to that line must hit without a new fill. A second overlap is a new fetch that is pending in the cycle the refill ends. That fetch must not be acknowledged until the line is written, and it is checked both for the wait and for the data it receives.

// File: rtl/fetch_line_cache.sv
module fetch_line_cache #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int CACHE_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ack,
  output logic [WORD_W-1:0] fetch_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int LINE_BYTES = (CACHE_BYTES >= 32768) ? 32 : 16;
  localparam int WORDS      = LINE_BYTES / 4;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int LINES      = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W      = $clog2(LINES);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [WORD_W-1:0] data_mem [LINES*WORDS];
  logic [LINES-1:0]  vld;

  logic              filling;
  logic [TAG_W-1:0]  fill_tag;
  logic [IDX_W-1:0]  fill_idx;
  logic [WSEL_W-1:0] fill_crit;
  logic [WSEL_W-1:0] beat;

  wire [IDX_W-1:0]  req_idx  = fetch_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  req_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] req_wsel = fetch_addr[2 +: WSEL_W];
  wire              unused_lsb = &{1'b0, fetch_addr[1:0]};

  wire lookup_hit = vld[req_idx] && (tag_mem[req_idx] == req_tag);
  wire beat_done  = filling && mem_ack;
  wire last_beat  = beat == WSEL_W'(WORDS - 1);
  wire forward    = beat_done && (beat == fill_crit);

  assign mem_req     = filling;
  assign mem_addr    = {fill_tag, fill_idx, beat, 2'b00};
  assign fetch_ack   = forward || (!filling && fetch_req && lookup_hit);
  assign fetch_rdata = filling ? mem_rdata : data_mem[{req_idx, req_wsel}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling   <= 1'b0;
      vld       <= '0;
      beat      <= '0;
      fill_tag  <= '0;
      fill_idx  <= '0;
      fill_crit <= '0;
    end else if (!filling) begin
      if (fetch_req && !lookup_hit) begin
        filling       <= 1'b1;
        fill_tag      <= req_tag;
        fill_idx      <= req_idx;
        fill_crit     <= req_wsel;
        beat          <= '0;
        vld[req_idx]  <= 1'b0;
      end
    end else if (mem_ack) begin
      beat <= beat + 1'b1;
      if (last_beat) begin
        filling       <= 1'b0;
        vld[fill_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (beat_done) begin
      data_mem[{fill_idx, beat}] <= mem_rdata;
      if (last_beat) tag_mem[fill_idx] <= fill_tag;
    end
  end
endmodule

// File: rtl/fetch_line_cache_chk.sv
module fetch_line_cache_chk #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int CACHE_BYTES = 8192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_ack,
  input logic [WORD_W-1:0] fetch_rdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [WORD_W-1:0] mem_rdata
);
  localparam int LINE_BYTES = (CACHE_BYTES >= 32768) ? 32 : 16;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WSEL_W     = OFF_W - 2;
  localparam logic [WSEL_W-1:0] LAST = WSEL_W'(LINE_BYTES / 4 - 1);

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack |-> fetch_req); // R1
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R4
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (mem_addr[OFF_W-1:2] != LAST) |=> mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R4
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R4
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_addr[OFF_W-1:0] == '0); // R4
  AST_FILL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (mem_addr[OFF_W-1:2] == LAST) |=> !mem_req); // R7
  AST_FWD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && mem_req |-> mem_ack && (fetch_rdata == mem_rdata)); // R5
  AST_FWD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && mem_req |-> mem_addr[ADDR_W-1:2] == fetch_addr[ADDR_W-1:2]); // R6
endmodule

bind fetch_line_cache fetch_line_cache_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CACHE_BYTES(CACHE_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .fetch_ack(fetch_ack), .fetch_rdata(fetch_rdata), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/fetch_line_cache_tb_top.sv
module fetch_line_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ack;
  logic [31:0] fetch_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int fills  = 0;
  int beat   = 0;
  int dly    = 0;
  logic [27:0] base = '0;
  logic        ref_v [512];
  logic [18:0] ref_t [512];

  always #5 clk = ~clk;

  fetch_line_cache dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .fetch_rdata(fetch_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return (w * 32'h9E3779B1) ^ {w[15:0], w[31:16]} ^ 32'h0BADF00D;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst_n) begin
        mem_ack = 1'b0; beat = 0; dly = 0;
      end else if (mem_req && dly == 0) begin
        if (beat == 0) begin
          fills++;
          base = mem_addr[31:4];
        end
        check(mem_addr[3:0] == 4'(beat * 4) && mem_addr[31:4] == base, "R4 beat address",
              mem_addr, {base, 4'(beat * 4)});
        mem_ack   = 1'b1;
        mem_rdata = mw(mem_addr);
        beat      = (beat + 1) % 4;
        dly       = int'($urandom % 3);
      end else begin
        mem_ack = 1'b0;
        if (mem_req && dly > 0) dly--;
      end
    end
  end

  task automatic do_fetch(input logic [31:0] a, input string req);
    logic [8:0]  ix = a[12:4];
    logic [18:0] tg = a[31:13];
    bit exp_hit = ref_v[ix] && ref_t[ix] == tg;
    bit busy0;
    int f0;
    int waited = 0;
    if (!exp_hit) begin
      ref_v[ix] = 1'b1;
      ref_t[ix] = tg;
    end
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    f0 = fills;
    busy0 = mem_req;
    forever begin
      #2;
      if (fetch_ack || waited > 300) break;
      waited++;
      @(negedge clk);
    end
    check(fetch_ack, {req, " ack seen"}, 32'(fetch_ack), 32'd1);
    check(fetch_rdata == mw(a), {req, " R8 data"}, fetch_rdata, mw(a));
    check((fills - f0) == (exp_hit ? 0 : 1), {req, " fill count"}, 32'(fills - f0), exp_hit ? 32'd0 : 32'd1);
    if (exp_hit && !busy0)
      check(waited == 0, {req, " R1 same-cycle hit"}, 32'(waited), 32'd0);
    if (mem_req)
      check(mem_ack && mem_addr[31:2] == a[31:2], busy0 ? {req, " R6 held off"} : {req, " R5 forward"},
            mem_addr, {a[31:2], 2'b00});
    @(posedge clk); #1;
    fetch_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    while (mem_req) @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 512; i++) ref_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [18:0] tags [4];
    tags[0] = 19'h00011; tags[1] = 19'h00012; tags[2] = 19'h7FFFF; tags[3] = 19'h00000;
    void'($urandom(32'd7));
    do_reset();
    #2;
    check(!mem_req && !fetch_ack, "R3 reset outputs", {30'd0, mem_req, fetch_ack}, 32'd0);
    do_fetch(32'h0002_2050, "R3 first fetch misses");
    do_fetch(32'h0002_2050, "R1 repeat hit");
    do_fetch(32'h0002_2054, "R7 other word hit");
    do_fetch(32'h0002_205C, "R8 last word hit");
    do_fetch(32'h0004_2050, "R2 conflicting tag");
    do_fetch(32'h0002_2050, "R2 displaced miss");
    do_fetch(32'h0008_307C, "R5 last-word miss");
    do_fetch(32'h0008_3070, "R7 line complete");
    do_fetch(32'h0010_4068, "R5 mid-line miss");
    do_fetch(32'h0010_4060, "R6 queued same line");
    do_fetch(32'h0010_4064, "R7 queued same line");
    do_fetch(32'h0020_508C, "R5 miss then queued other line");
    do_fetch(32'h0030_6090, "R6 queued miss");
    do_reset();
    do_fetch(32'h0002_2050, "R3 miss after reset");
    for (int n = 0; n < 400; n++) begin
      logic [8:0] ix = (n % 7 == 0) ? 9'd511 : 9'($urandom % 8);
      do_fetch({tags[$urandom % 4], ix, 2'($urandom % 4), 2'b00}, "R1 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule